// File: doc/BRIEF.md
# Sectored Flash Programming Sequencer

This block writes a run of 32-bit words into a serial flash. It does not drive the flash pins. It works through a register-style access port that has a data register and an address register. Writing the address register with its completion flag set starts a device operation. The device clears the flag when it is done. A host starts a job with a pulse that carries a start word address, a word count and two device options. The options are a sector-size select and an alternate erase-command location. The data words then arrive over a valid/ready stream.

A job always runs in the same order. The sequencer first raises a flash-enable output and clears the write protection. It then takes the words one at a time. When a word's address is the first address of a sector, an erase command for that sector is issued before the word is written. Each command is followed by a poll of the completion flag. The poll is sampled every `POLL_DIV` cycles and gives up after `MAX_POLLS` busy samples. A timeout on an erase or a word write aborts the job: the remaining words are neither requested nor written. The protection is restored whether the job succeeded or aborted. After that the flash-enable is dropped and a one-cycle `done` pulse reports the result together with the address that failed.

The controller is built around six states:
- IDLE: waiting for `start`.
- LOAD_DATA: writes the data register.
- LOAD_ADDR: writes the address register, with the flag set.
- POLL: waits for completion or a timeout.
- FETCH: waits for the next stream word.
- FINISH: drops the enable and reports.

The transitions are:
- IDLE goes to LOAD_DATA on `start`.
- LOAD_DATA goes to LOAD_ADDR.
- LOAD_ADDR goes to POLL.
- POLL goes to FETCH when another word is due, to FINISH after the protection-restore command, and to LOAD_DATA in every other case.
- FETCH goes to LOAD_DATA when a word is accepted.
- FINISH goes to IDLE.

A phase register tracks which command is outstanding: unprotect, erase, word or reprotect.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `flash_en`, `wr_ready`, `done`, `port_data_we`, `port_addr_we` and `ok` are all low.
- R2: On `start`, `flash_en` rises. The first command is a configuration-space write (`port_cfg`=1) of data 0 to address 0x101. `flash_en` stays high on every access-port strobe.
- R3: A command is one cycle of `port_data_we`, followed in the next cycle by one cycle of `port_addr_we`. The address write always sets the completion flag. A word command uses data space (`port_cfg`=0), the word address as the address, and the stream word as the data.
- R4: A word whose address ANDed with the in-sector mask is zero is preceded by an erase command. The mask is 0x3FFF when `small_sector`=0 and 0x1FFF when `small_sector`=1.
- R5: The erase command writes to configuration address 0x3D8, or to 0x352 when `alt_erase`=1. Its data is built from the sector address S = (word address AND NOT in-sector mask) shifted left by 2. The data is {8'h00, S[7:0], S[15:8], S[23:16]}.
- R6: A command completes at the first poll sample, every `POLL_DIV` cycles, that sees `port_flag` low. `wr_ready` is raised for the next word only after the previous word's command has completed.
- R7: If `MAX_POLLS` consecutive samples of an erase or word command see the flag high, the job fails. `fail_addr` is that word's address, `ok` is 0, and no further words are accepted or written.
- R8: The last command of every job, including a failed one, is a configuration write of 0x9C to address 0x101. After it finishes, `flash_en` falls and `done` pulses for one cycle with `busy` low. `ok` is 1 only if nothing failed.
- R9: With a word count of 0, only the unprotect and reprotect commands are issued and no word is accepted.
- R10: A timeout on the unprotect or reprotect command does not fail the job, and the sequence goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, ignored while busy |
| start_addr | input | AW | First word address |
| word_count | input | CW | Number of words to program |
| small_sector | input | 1 | Selects the smaller sector size |
| alt_erase | input | 1 | Selects the alternate erase-command location |
| wr_data | input | 32 | Stream data word |
| wr_valid | input | 1 | Stream word valid |
| wr_ready | output | 1 | Stream word accepted |
| port_data_we | output | 1 | Data register write strobe |
| port_data | output | 32 | Data register value |
| port_addr_we | output | 1 | Address register write strobe (flag set) |
| port_cfg | output | 1 | Address is in configuration space |
| port_addr | output | AW | Address register value |
| port_flag | input | 1 | Completion flag readback, high while busy |
| flash_en | output | 1 | Flash write enable control |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| ok | output | 1 | Last job succeeded |
| fail_addr | output | AW | Word address of the failure |

## Verification
The bench builds the block with `POLL_DIV`=2, `MAX_POLLS`=8 and `CW`=8. With these values a timeout costs only 16 cycles, so the bench can hang the device on every single command of a job in turn: the unprotect, each erase, each word and the reprotect. The address width stays at its default, which keeps the real sector masks. Start addresses are swept around both boundary sizes, at 0x3FFC to 0x4001 and at 0x1FFC to 0x2001. These sweeps are combined with counts from 0 to 4, both sector sizes, both erase locations and device latencies of 0, 3 and 14 cycles. The latency of 14 makes the flag clear on the last sample before the timeout.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_DATA,
        ST_LOAD_ADDR,
        ST_POLL,
        ST_FETCH,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_UNPROT,
        PH_ERASE,
        PH_WORD,
        PH_REPROT
    } seq_phase_t;

    localparam logic [11:0] PROT_LOC     = 12'h101;
    localparam logic [31:0] PROT_OFF_VAL = 32'h0000_0000;
    localparam logic [31:0] PROT_ON_VAL  = 32'h0000_009C;
    localparam logic [11:0] ERASE_LOC    = 12'h3D8;
    localparam logic [11:0] ERASE_LOC_ALT = 12'h352;

endpackage

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
    parameter int POLL_DIV  = 4,
    parameter int MAX_POLLS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic active,
    input  logic flag_busy,
    output logic complete,
    output logic timeout
);
    localparam int DW = $clog2(POLL_DIV + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [DW-1:0] div_q;
    logic [PW-1:0] polls_q;
    logic          sample;

    assign sample   = active && (div_q == DW'(POLL_DIV - 1));
    assign complete = sample && !flag_busy;
    assign timeout  = sample && flag_busy && (polls_q == PW'(MAX_POLLS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            polls_q <= '0;
        end else if (arm) begin
            div_q   <= '0;
            polls_q <= '0;
        end else if (active) begin
            if (sample) begin
                div_q <= '0;
                if (flag_busy) polls_q <= polls_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fps_sector_calc.sv
module fps_sector_calc #(
    parameter int          AW         = 18,
    parameter logic [31:0] BIG_MASK   = 32'h3FFF,
    parameter logic [31:0] SMALL_MASK = 32'h1FFF
) (
    input  logic [AW-1:0] addr,
    input  logic          small_sector,
    input  logic          alt_erase,
    output logic          at_boundary,
    output logic [31:0]   erase_arg,
    output logic [AW-1:0] erase_loc
);
    import flash_seq_pkg::*;

    logic [AW-1:0] in_mask;
    logic [31:0]   sect;

    assign in_mask     = small_sector ? AW'(SMALL_MASK) : AW'(BIG_MASK);
    assign at_boundary = ((addr & in_mask) == '0);
    assign sect        = 32'(addr & ~in_mask) << 2;

    // Byte 1 stays; bytes 0 and 2 exchange places; byte 3 is zero.
    for (genvar b = 0; b < 4; b++) begin : g_byte
        localparam int SRC = (b == 0) ? 2 : (b == 2) ? 0 : b;
        if (b == 3) begin : g_zero
            assign erase_arg[8*b +: 8] = 8'h00;
        end else begin : g_move
            assign erase_arg[8*b +: 8] = sect[8*SRC +: 8];
        end
    end

    assign erase_loc = alt_erase ? AW'(ERASE_LOC_ALT) : AW'(ERASE_LOC);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
    parameter int          AW         = 18,
    parameter int          CW         = 16,
    parameter int          POLL_DIV   = 4,
    parameter int          MAX_POLLS  = 500000,
    parameter logic [31:0] BIG_MASK   = 32'h3FFF,
    parameter logic [31:0] SMALL_MASK = 32'h1FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] word_count,
    input  logic          small_sector,
    input  logic          alt_erase,
    input  logic [31:0]   wr_data,
    input  logic          wr_valid,
    output logic          wr_ready,
    output logic          port_data_we,
    output logic [31:0]   port_data,
    output logic          port_addr_we,
    output logic          port_cfg,
    output logic [AW-1:0] port_addr,
    input  logic          port_flag,
    output logic          flash_en,
    output logic          busy,
    output logic          done,
    output logic          ok,
    output logic [AW-1:0] fail_addr
);
    import flash_seq_pkg::*;

    seq_state_t    state_q, state_d;
    seq_phase_t    phase_q;
    logic [AW-1:0] cur_addr_q;
    logic [CW-1:0] remain_q;
    logic [31:0]   word_q;
    logic          fail_q;
    logic          cmd_cfg_q;
    logic [AW-1:0] cmd_addr_q;
    logic [31:0]   cmd_data_q;
    logic          en_q, done_q, ok_q;
    logic [AW-1:0] fail_addr_q;

    logic          poll_complete, poll_timeout, poll_end;
    logic          at_boundary;
    logic [31:0]   erase_arg;
    logic [AW-1:0] erase_loc;

    fps_poll_timer #(
        .POLL_DIV (POLL_DIV),
        .MAX_POLLS(MAX_POLLS)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (state_q == ST_LOAD_ADDR),
        .active   (state_q == ST_POLL),
        .flag_busy(port_flag),
        .complete (poll_complete),
        .timeout  (poll_timeout)
    );

    fps_sector_calc #(
        .AW        (AW),
        .BIG_MASK  (BIG_MASK),
        .SMALL_MASK(SMALL_MASK)
    ) u_sect (
        .addr        (cur_addr_q),
        .small_sector(small_sector),
        .alt_erase   (alt_erase),
        .at_boundary (at_boundary),
        .erase_arg   (erase_arg),
        .erase_loc   (erase_loc)
    );

    assign poll_end = poll_complete || poll_timeout;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_LOAD_DATA;
            ST_LOAD_DATA: state_d = ST_LOAD_ADDR;
            ST_LOAD_ADDR: state_d = ST_POLL;
            ST_POLL: begin
                if (poll_end) begin
                    if (phase_q == PH_REPROT)
                        state_d = ST_FINISH;
                    else if ((phase_q == PH_UNPROT && remain_q != '0) ||
                             (phase_q == PH_WORD && poll_complete && remain_q != CW'(1)))
                        state_d = ST_FETCH;
                    else
                        state_d = ST_LOAD_DATA;
                end
            end
            ST_FETCH:     if (wr_valid) state_d = ST_LOAD_DATA;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Job datapath and command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= PH_UNPROT;
            cur_addr_q  <= '0;
            remain_q    <= '0;
            word_q      <= '0;
            fail_q      <= 1'b0;
            cmd_cfg_q   <= 1'b0;
            cmd_addr_q  <= '0;
            cmd_data_q  <= '0;
            en_q        <= 1'b0;
            done_q      <= 1'b0;
            ok_q        <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_addr_q  <= start_addr;
                        remain_q    <= word_count;
                        fail_q      <= 1'b0;
                        fail_addr_q <= '0;
                        en_q        <= 1'b1;
                        phase_q     <= PH_UNPROT;
                        cmd_cfg_q   <= 1'b1;
                        cmd_addr_q  <= AW'(PROT_LOC);
                        cmd_data_q  <= PROT_OFF_VAL;
                    end
                end
                ST_POLL: begin
                    if (poll_end) begin
                        unique case (phase_q)
                            PH_UNPROT: begin
                                if (remain_q == '0) begin
                                    phase_q    <= PH_REPROT;
                                    cmd_data_q <= PROT_ON_VAL;
                                end
                            end
                            PH_ERASE: begin
                                if (poll_timeout) begin
                                    fail_q      <= 1'b1;
                                    fail_addr_q <= cur_addr_q;
                                    phase_q     <= PH_REPROT;
                                    cmd_cfg_q   <= 1'b1;
                                    cmd_addr_q  <= AW'(PROT_LOC);
                                    cmd_data_q  <= PROT_ON_VAL;
                                end else begin
                                    phase_q    <= PH_WORD;
                                    cmd_cfg_q  <= 1'b0;
                                    cmd_addr_q <= cur_addr_q;
                                    cmd_data_q <= word_q;
                                end
                            end
                            PH_WORD: begin
                                if (poll_timeout) begin
                                    fail_q      <= 1'b1;
                                    fail_addr_q <= cur_addr_q;
                                end else begin
                                    cur_addr_q <= cur_addr_q + 1'b1;
                                    remain_q   <= remain_q - 1'b1;
                                end
                                if (poll_timeout || remain_q == CW'(1)) begin
                                    phase_q    <= PH_REPROT;
                                    cmd_cfg_q  <= 1'b1;
                                    cmd_addr_q <= AW'(PROT_LOC);
                                    cmd_data_q <= PROT_ON_VAL;
                                end
                            end
                            PH_REPROT: ;
                            default: ;
                        endcase
                    end
                end
                ST_FETCH: begin
                    if (wr_valid) begin
                        word_q <= wr_data;
                        if (at_boundary) begin
                            phase_q    <= PH_ERASE;
                            cmd_cfg_q  <= 1'b1;
                            cmd_addr_q <= erase_loc;
                            cmd_data_q <= erase_arg;
                        end else begin
                            phase_q    <= PH_WORD;
                            cmd_cfg_q  <= 1'b0;
                            cmd_addr_q <= cur_addr_q;
                            cmd_data_q <= wr_data;
                        end
                    end
                end
                ST_FINISH: begin
                    en_q   <= 1'b0;
                    done_q <= 1'b1;
                    ok_q   <= !fail_q;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        port_data_we = (state_q == ST_LOAD_DATA);
        port_addr_we = (state_q == ST_LOAD_ADDR);
        wr_ready     = (state_q == ST_FETCH);
        busy         = (state_q != ST_IDLE);
        port_cfg     = cmd_cfg_q;
        port_addr    = cmd_addr_q;
        port_data    = cmd_data_q;
        flash_en     = en_q;
        done         = done_q;
        ok           = ok_q;
        fail_addr    = fail_addr_q;
    end
endmodule

// File: rtl/fps_checker.sv
module fps_checker (
    input logic clk,
    input logic rst_n,
    input logic port_data_we,
    input logic port_addr_we,
    input logic wr_ready,
    input logic flash_en,
    input logic busy,
    input logic done
);
    AST_DATA_BEFORE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        port_addr_we |-> $past(port_data_we)) else $error("data before address"); // R3
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_data_we && port_addr_we)) else $error("strobe overlap"); // R3
    AST_ENABLE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_data_we || port_addr_we) |-> flash_en) else $error("access without enable"); // R2
    AST_READY_IN_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (busy && flash_en && !port_addr_we)) else $error("ready outside job"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done too long"); // R8
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !flash_en)) else $error("done while active"); // R8
endmodule

bind flash_prog_seq fps_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_data_we(port_data_we),
    .port_addr_we(port_addr_we),
    .wr_ready    (wr_ready),
    .flash_en    (flash_en),
    .busy        (busy),
    .done        (done)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
    localparam int AW = 18;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic          small_sector = 1'b0;
    logic          alt_erase = 1'b0;
    logic [31:0]   wr_data;
    logic          wr_valid = 1'b0;
    logic          wr_ready, port_data_we, port_addr_we, port_cfg;
    logic [31:0]   port_data;
    logic [AW-1:0] port_addr;
    logic          port_flag;
    logic          flash_en, busy, done, ok;
    logic [AW-1:0] fail_addr;

    always #4 clk = ~clk;

    flash_prog_seq #(.AW(AW), .CW(CW), .POLL_DIV(2), .MAX_POLLS(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_count(word_count), .small_sector(small_sector), .alt_erase(alt_erase),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .port_data_we(port_data_we), .port_data(port_data), .port_addr_we(port_addr_we),
        .port_cfg(port_cfg), .port_addr(port_addr), .port_flag(port_flag),
        .flash_en(flash_en), .busy(busy), .done(done), .ok(ok), .fail_addr(fail_addr)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Device model and command log
    logic [31:0] dreg = '0;
    int          dev_cnt = 0;
    logic        dev_hang = 1'b0;
    int          stuck_idx = -1;
    int          lat = 3;
    int          log_n = 0;
    logic        log_cfg [0:63];
    logic [31:0] log_addr [0:63];
    logic [31:0] log_data [0:63];
    int          consumed = 0;
    int          bad_ready = 0;

    assign port_flag = dev_hang || (dev_cnt > 0);
    assign wr_data   = 32'hC0DE_0000 + 32'(start_addr) + 32'(consumed);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (dev_cnt > 0) dev_cnt <= dev_cnt - 1;
        if (port_data_we) dreg <= port_data;
        if (port_addr_we) begin
            if (log_n < 64) begin
                log_cfg[log_n]  <= port_cfg;
                log_addr[log_n] <= 32'(port_addr);
                log_data[log_n] <= dreg;
            end
            log_n    <= log_n + 1;
            dev_hang <= (log_n == stuck_idx);
            dev_cnt  <= lat;
        end
        if (wr_valid && wr_ready) consumed <= consumed + 1;
        if (wr_ready && port_flag && !dev_hang) bad_ready <= bad_ready + 1;
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected command list
    logic        e_cfg [0:63];
    logic [31:0] e_addr [0:63];
    logic [31:0] e_data [0:63];
    int          e_n;

    function automatic logic [31:0] erase_arg_of(input logic [31:0] a, input bit sm);
        logic [31:0] inm, s;
        inm = sm ? 32'h1FFF : 32'h3FFF;
        s = (a & 32'h3FFFF & ~inm) << 2;
        return {8'h00, s[7:0], s[15:8], s[23:16]};
    endfunction

    task automatic push(input logic c, input logic [31:0] a, input logic [31:0] d);
        e_cfg[e_n] = c; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
    endtask

    task automatic run(input int sa, input int cnt, input bit sm, input bit alt,
                       input int stuck, input int l);
        int  exp_words, guard;
        bit  exp_fail;
        int  exp_fa;
        logic [31:0] inm;
        // Build expectation (R2..R5, R7..R10)
        e_n = 0; exp_words = 0; exp_fail = 0; exp_fa = 0;
        inm = sm ? 32'h1FFF : 32'h3FFF;
        push(1'b1, 32'h101, 32'h0);
        for (int i = 0; i < cnt; i++) begin
            logic [31:0] a;
            if (exp_fail) break;
            a = 32'(sa + i);
            exp_words++;
            if ((a & inm) == 0) begin
                push(1'b1, alt ? 32'h352 : 32'h3D8, erase_arg_of(a, sm));
                if (e_n - 1 == stuck) begin exp_fail = 1; exp_fa = a; continue; end
            end
            push(1'b0, a, 32'hC0DE_0000 + a);
            if (e_n - 1 == stuck) begin exp_fail = 1; exp_fa = a; end
        end
        push(1'b1, 32'h101, 32'h9C);

        @(negedge clk);
        log_n = 0; consumed = 0; bad_ready = 0; stuck_idx = stuck; lat = l;
        start_addr = AW'(sa); word_count = CW'(cnt);
        small_sector = sm; alt_erase = alt; wr_valid = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && flash_en, "R2", "enable raised at start", {30'b0, busy, flash_en}, 32'h3);
        guard = 0;
        while (!done && guard < 4000) begin @(negedge clk); guard++; end
        chk(done, "R8", "job finished", {31'b0, done}, 32'h1);
        chk(!busy && !flash_en, "R8", "idle and disabled at done", {30'b0, busy, flash_en}, 32'h0);
        chk(ok == !exp_fail, exp_fail ? "R7" : "R8", "ok flag", {31'b0, ok}, {31'b0, !exp_fail});
        if (exp_fail)
            chk(32'(fail_addr) == exp_fa, "R7", "fail address", 32'(fail_addr), exp_fa);
        chk(consumed == exp_words, cnt == 0 ? "R9" : "R7", "words accepted", consumed, exp_words);
        chk(log_n == e_n, "R3", "command count", log_n, e_n);
        for (int k = 0; k < e_n && k < log_n; k++) begin
            string rq;
            rq = (k == 0) ? "R2" : (k == e_n - 1) ? "R8" :
                 e_cfg[k] ? "R5" : "R3";
            chk(log_cfg[k] == e_cfg[k] && log_addr[k] == e_addr[k] && log_data[k] == e_data[k],
                rq, $sformatf("command %0d addr/data", k), log_addr[k] ^ log_data[k],
                e_addr[k] ^ e_data[k]);
        end
        chk(bad_ready == 0, "R6", "ready only after completion", bad_ready, 0);
        @(negedge clk);
        chk(!done, "R8", "done is one cycle", {31'b0, done}, 32'h0);
        wr_valid = 1'b0;
        dev_hang = 1'b0;
    endtask

    initial begin : watchdog
        while (cycles < 150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=done", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !flash_en && !wr_ready && !done && !port_data_we && !port_addr_we && !ok,
            "R1", "reset quiet", {25'b0, busy, flash_en, wr_ready, done, port_data_we, port_addr_we, ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !flash_en, "R1", "idle after reset", {30'b0, busy, flash_en}, 0);

        // R4/R5 boundary sweeps for both sector sizes and erase locations
        for (int sm = 0; sm < 2; sm++)
            for (int alt = 0; alt < 2; alt++)
                for (int off = -4; off <= 1; off++)
                    for (int cnt = 1; cnt <= 4; cnt++)
                        run((sm ? 32'h2000 : 32'h4000) + off, cnt, sm[0], alt[0], -1,
                            (off + cnt) % 3 == 0 ? 0 : 3);
        // R4: first word at address 0 erases sector 0
        run(0, 3, 1'b0, 1'b0, -1, 3);
        // R9: zero count
        run(32'h123, 0, 1'b0, 1'b0, -1, 3);
        // R6: flag clears at the last permitted sample
        run(32'h3FFE, 3, 1'b0, 1'b0, -1, 14);
        // R7: hang on each command of a job crossing a boundary
        for (int s = 1; s <= 4; s++) run(32'h3FFE, 3, 1'b0, 1'b1, s, 3);
        run(32'h1FFF, 3, 1'b1, 1'b0, 3, 0);
        // R10: hang on unprotect and on reprotect
        run(32'h10, 2, 1'b0, 1'b0, 0, 3);
        run(32'h10, 2, 1'b0, 1'b0, 3, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule